// File: doc/BRIEF.md
# Looping Serial Audio DMA Engine

This block moves audio between a one-bit serial codec link and system memory without stopping. Software programs a capture base address, a playback base address and one length shared by both buffers, then sets enable bits in a control register. From then on the engine walks both buffers in step. It packs incoming serial bits into 32-bit words and writes them to the capture buffer. It reads playback words and shifts them out one bit at a time. When the shared bit count runs out, both positions jump back to their bases and the walk starts again.

The bit rate comes from a clock divider with three settings, chosen by a two-bit rate code in the control register. A strobe marks each bit slot. A pass-through mode routes the captured bit stream to the serial output and also stores every captured word in the playback buffer. A read-only down-counter tells software how many bits remain before the current buffer pass completes. The register window repeats every 32 bytes.

Top module: `audStreamDma`

## Requirements
- R1: After reset, every register reads back as zero except the source register, which reads 0x00350000. `sdOut`, `memWrEn` and `memRdEn` are low.
- R2: Only byte address bits 4:2 select a register, so the map repeats every 32 bytes. The slots are: 0x00 control (16 bits), 0x04 source, 0x0C bits-left counter (16 bits, read-only), 0x10 capture base, 0x14 playback base, 0x18 length (16 bits). All other slots read zero.
- R3: The strobe `frameStb` pulses once per bit slot, and the spacing between pulses is set by the rate code {control bit 11, control bit 9}. Code 10 or 11 gives DIV_FAST clocks, code 01 gives DIV_MID clocks and code 00 gives DIV_SLOW clocks.
- R4: The first strobe of a buffer pass loads length×64 into the counter and subtracts one. Every later strobe subtracts one more. The counter then reads zero until the next strobe starts a new pass.
- R5: Control bit 7 enables capture. On each strobe, `sdIn` is sampled into a word, most significant bit first. Word k of a pass is written to capture base + 4k in the cycle after its 32nd bit. No writes happen while bit 7 is clear.
- R6: A pass covers length×2 words. The next pass starts again at both base addresses.
- R7: With control bit 8 set and pass-through off, word k is read from playback base + 4k on the strobe of its first bit. Its bits then appear on `sdOut` MSB first, each valid from the second cycle after its strobe.
- R8: Control bit 2 is the output enable. While it is clear, `sdOut` stays low.
- R9: Pass-through is active when control bits 6 and 7 are both set. In this mode each captured bit appears on `sdOut` with the same timing as in R7, playback reads stop, and each finished word is written to the capture buffer and then, one cycle later, to playback base + 4k.
- R10: Writing zero to the control register stops the engine. From the next cycle there are no memory accesses and no strobes, the counter reads zero, and `sdOut` is low one cycle later.
- R11: The source register stores a 4-bit volume in bits 15:12. It accepts a write to the select field in bits 23:20 only when the value is 3 or 4, and otherwise keeps the old select. Bits 19:16 always read 5.
- R12: While the length is zero the engine stays idle and produces no strobes, even with enable bits set.
- R13: A read and a write never share a memory cycle, and strobes never come on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for the slot at regAddr (combinational) |
| memWrEn | output | 1 | Memory word write |
| memRdEn | output | 1 | Memory word read; data is expected on memRdData in the next cycle |
| memAddr | output | 32 | Memory byte address |
| memWrData | output | 32 | Memory write data |
| memRdData | input | 32 | Memory read data |
| sdIn | input | 1 | Serial capture bit |
| sdOut | output | 1 | Serial playback bit |
| frameStb | output | 1 | One-cycle pulse per serial bit slot |

## Verification
The bench builds the block with dividers of 6, 12 and 13 clocks and a 9-bit register address. It programs a length of one unit, which makes each buffer pass 64 bits, or two words, long. With these values a full pass and its wrap to the bases take a few hundred cycles, so the reload, the return to the bases, all three rate codes and the mirrored window can each be observed directly. The short divider also keeps the strobes only a few cycles apart, close to the limit of the serialized pass-through writes.

// File: rtl/audStreamPkg.sv
package audStreamPkg;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 32;
  localparam int LEN_W      = 16;
  localparam int UNIT_SHIFT = 6;                       // one length unit = 64 bits
  localparam int BIT_IDX_W  = $clog2(WORD_W);
  localparam int CNT_W      = LEN_W + UNIT_SHIFT;
  localparam int CNT_OUT_W  = 16;
  localparam int IDX_W      = LEN_W + UNIT_SHIFT - BIT_IDX_W;

  // control register bit positions
  localparam int CB_OUT_EN  = 2;
  localparam int CB_PASS    = 6;
  localparam int CB_CAP     = 7;
  localparam int CB_PLAY    = 8;
  localparam int CB_RATE_LO = 9;
  localparam int CB_RATE_HI = 11;

  // register slots (byte address bits 4:2)
  localparam logic [2:0] SLOT_CTRL    = 3'd0;
  localparam logic [2:0] SLOT_SRC     = 3'd1;
  localparam logic [2:0] SLOT_LEFT    = 3'd3;
  localparam logic [2:0] SLOT_INBASE  = 3'd4;
  localparam logic [2:0] SLOT_OUTBASE = 3'd5;
  localparam logic [2:0] SLOT_LEN     = 3'd6;

  typedef struct packed {
    logic             run;
    logic             tick;
    logic             wordStart;
    logic             wordEnd;
    logic             capOn;
    logic             passOn;
    logic             playOn;
    logic             outEnable;
    logic [IDX_W-1:0] wordIdx;
  } dmaStb_t;
endpackage

// File: rtl/audStreamCtl.sv
module audStreamCtl
  import audStreamPkg::*;
#(
  parameter int REG_AW   = 9,
  parameter int DIV_FAST = 2604,
  parameter int DIV_MID  = 5208,
  parameter int DIV_SLOW = 5669
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic [ADDR_W-1:0] inBase,
  output logic [ADDR_W-1:0] outBase,
  output dmaStb_t           stb
);
  localparam int DIV_MAX = (DIV_FAST > DIV_MID) ? ((DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW)
                                                : ((DIV_MID > DIV_SLOW) ? DIV_MID : DIV_SLOW);
  localparam int DIV_W = $clog2(DIV_MAX + 1);

  logic [15:0]          ctrlReg;
  logic [3:0]           volReg, selReg;
  logic [LEN_W-1:0]     lenReg;
  logic [DIV_W-1:0]     divCnt, divLimit;
  logic [CNT_W-1:0]     bitsLeft, reload;
  logic [BIT_IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0]     wordIdx, effIdx;
  logic                 run, tick, bufStart;
  logic [2:0]           slot;
  logic                 unusedAddrBits;

  assign slot           = regAddr[4:2];
  assign unusedAddrBits = ^{regAddr[REG_AW-1:5], regAddr[1:0]};

  always_comb begin
    case ({ctrlReg[CB_RATE_HI], ctrlReg[CB_RATE_LO]})
      2'b01:   divLimit = DIV_W'(DIV_MID - 1);
      2'b00:   divLimit = DIV_W'(DIV_SLOW - 1);
      default: divLimit = DIV_W'(DIV_FAST - 1);
    endcase
  end

  assign run      = (ctrlReg[CB_CAP] | ctrlReg[CB_PLAY]) && (lenReg != '0);
  assign tick     = run && (divCnt >= divLimit);
  assign bufStart = (bitsLeft == '0);
  assign effIdx   = bufStart ? '0 : wordIdx;
  assign reload   = CNT_W'(lenReg) << UNIT_SHIFT;

  // software-visible registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      volReg  <= '0;
      selReg  <= 4'd3;
      lenReg  <= '0;
      inBase  <= '0;
      outBase <= '0;
    end else if (regWrEn) begin
      case (slot)
        SLOT_CTRL:    ctrlReg <= regWrData[15:0];
        SLOT_SRC: begin
          volReg <= regWrData[15:12];
          if (regWrData[23:20] == 4'd3 || regWrData[23:20] == 4'd4) selReg <= regWrData[23:20];
        end
        SLOT_INBASE:  inBase  <= regWrData;
        SLOT_OUTBASE: outBase <= regWrData;
        SLOT_LEN:     lenReg  <= regWrData[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  // bit-slot timing and buffer position
  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      divCnt   <= '0;
      bitsLeft <= '0;
      bitIdx   <= '0;
      wordIdx  <= '0;
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) begin
        bitsLeft <= (bufStart ? reload : bitsLeft) - CNT_W'(1);
        bitIdx   <= bitIdx + 1'b1;
        wordIdx  <= (bitIdx == '1) ? effIdx + 1'b1 : effIdx;
      end
    end
  end

  always_comb begin
    case (slot)
      SLOT_CTRL:    regRdData = {16'h0, ctrlReg};
      SLOT_SRC:     regRdData = {8'h0, selReg, 4'h5, volReg, 12'h0};
      SLOT_LEFT:    regRdData = 32'(bitsLeft[CNT_OUT_W-1:0]);
      SLOT_INBASE:  regRdData = inBase;
      SLOT_OUTBASE: regRdData = outBase;
      SLOT_LEN:     regRdData = 32'(lenReg);
      default:      regRdData = '0;
    endcase
  end

  assign stb.run       = run;
  assign stb.tick      = tick;
  assign stb.wordStart = (bitIdx == '0);
  assign stb.wordEnd   = (bitIdx == '1);
  assign stb.capOn     = ctrlReg[CB_CAP];
  assign stb.passOn    = ctrlReg[CB_PASS] & ctrlReg[CB_CAP];
  assign stb.playOn    = ctrlReg[CB_PLAY] & ~(ctrlReg[CB_PASS] & ctrlReg[CB_CAP]);
  assign stb.outEnable = ctrlReg[CB_OUT_EN];
  assign stb.wordIdx   = effIdx;

  // R13
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN) stb.tick |=> !stb.tick);
  // R11
  src_sel_chk: assert property (@(posedge clk) disable iff (!rstN) (selReg == 4'd3 || selReg == 4'd4));
  // R12
  idle_len_chk: assert property (@(posedge clk) disable iff (!rstN) (lenReg == '0) |=> (bitsLeft == '0));
endmodule

// File: rtl/audStreamPath.sv
module audStreamPath
  import audStreamPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dmaStb_t           stb,
  input  logic [ADDR_W-1:0] inBase,
  input  logic [ADDR_W-1:0] outBase,
  input  logic              sdIn,
  output logic              sdOut,
  output logic              memWrEn,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWrData,
  input  logic [WORD_W-1:0] memRdData
);
  logic [WORD_W-1:0] capShift, capWord, capNext, playShift;
  logic [IDX_W-1:0]  pendIdx;
  logic              pendIn, pendOut, capBitD, tickD, startD, sdOutReg, outBit;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  assign capNext   = {capShift[WORD_W-2:0], sdIn};
  assign wrAddr    = (pendIn ? inBase : outBase) + ADDR_W'({pendIdx, 2'b00});
  assign rdAddr    = outBase + ADDR_W'({stb.wordIdx, 2'b00});
  assign memWrEn   = stb.run && (pendIn || pendOut);
  assign memRdEn   = stb.tick && stb.wordStart && stb.playOn;
  assign memAddr   = memWrEn ? wrAddr : rdAddr;
  assign memWrData = capWord;
  assign sdOut     = sdOutReg;

  always_comb begin
    if (stb.passOn)      outBit = capBitD;
    else if (stb.playOn) outBit = startD ? memRdData[WORD_W-1] : playShift[WORD_W-1];
    else                 outBit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !stb.run) begin
      capShift  <= '0;
      capWord   <= '0;
      playShift <= '0;
      pendIdx   <= '0;
      pendIn    <= 1'b0;
      pendOut   <= 1'b0;
      capBitD   <= 1'b0;
      tickD     <= 1'b0;
      startD    <= 1'b0;
      sdOutReg  <= 1'b0;
    end else begin
      tickD  <= stb.tick;
      startD <= stb.tick && stb.wordStart;
      if (stb.tick) begin
        capShift <= capNext;
        capBitD  <= sdIn;
      end
      if (stb.tick && stb.wordEnd) begin
        capWord <= capNext;
        pendIn  <= stb.capOn;
        pendOut <= stb.passOn;
        pendIdx <= stb.wordIdx;
      end else if (pendIn) begin
        pendIn <= 1'b0;
      end else if (pendOut) begin
        pendOut <= 1'b0;
      end
      if (tickD) begin
        sdOutReg <= outBit & stb.outEnable;
        if (stb.playOn)
          playShift <= startD ? {memRdData[WORD_W-2:0], 1'b0} : {playShift[WORD_W-2:0], 1'b0};
      end
    end
  end

  // R13
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(memWrEn && memRdEn));
  // R9
  pass_noread_chk: assert property (@(posedge clk) disable iff (!rstN) stb.passOn |-> !memRdEn);
  // R10
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rstN) !stb.run |=> !sdOut);
endmodule

// File: rtl/audStreamDma.sv
module audStreamDma
  import audStreamPkg::*;
#(
  parameter int REG_AW   = 9,
  parameter int DIV_FAST = 2604,
  parameter int DIV_MID  = 5208,
  parameter int DIV_SLOW = 5669
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              memWrEn,
  output logic              memRdEn,
  output logic [31:0]       memAddr,
  output logic [31:0]       memWrData,
  input  logic [31:0]       memRdData,
  input  logic              sdIn,
  output logic              sdOut,
  output logic              frameStb
);
  dmaStb_t           stb;
  logic [ADDR_W-1:0] inBase, outBase;

  audStreamCtl #(
    .REG_AW(REG_AW), .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)
  ) uCtl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .inBase(inBase), .outBase(outBase), .stb(stb)
  );

  audStreamPath uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .inBase(inBase), .outBase(outBase),
    .sdIn(sdIn), .sdOut(sdOut), .memWrEn(memWrEn), .memRdEn(memRdEn),
    .memAddr(memAddr), .memWrData(memWrData), .memRdData(memRdData)
  );

  assign frameStb = stb.tick;

  // R10
  stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr[4:2] == SLOT_CTRL && regWrData[15:0] == 16'h0) |=> (!memWrEn && !memRdEn));
endmodule

// File: tb/sim_audStreamDma.sv
`timescale 1ns/1ps
module sim_audStreamDma;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [8:0]  regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic        memWrEn, memRdEn, sdOut, frameStb;
  logic        sdIn = 1'b0;
  logic [31:0] memAddr, memWrData;
  logic [31:0] memRdData = '0;

  logic [31:0] mem [0:63];
  logic [31:0] logA [0:15];
  logic [31:0] logD [0:15];
  int wrN = 0, rdN = 0, clash = 0, stbN = 0, b2b = 0;
  logic prevStb = 1'b0;
  int nChecks = 0, nFail = 0;

  always #4 clk = ~clk;   // 125 MHz

  audStreamDma #(.REG_AW(9), .DIV_FAST(6), .DIV_MID(12), .DIV_SLOW(13)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memWrEn(memWrEn),
    .memRdEn(memRdEn), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData), .sdIn(sdIn), .sdOut(sdOut), .frameStb(frameStb)
  );

  // memory model and monitors
  always @(posedge clk) begin
    if (memWrEn) begin
      mem[memAddr[7:2]] <= memWrData;
      logA[wrN[3:0]] <= memAddr;
      logD[wrN[3:0]] <= memWrData;
      wrN <= wrN + 1;
    end
    if (memRdEn) begin
      memRdData <= mem[memAddr[7:2]];
      rdN <= rdN + 1;
    end
    if (memWrEn && memRdEn) clash <= clash + 1;
    if (frameStb) stbN <= stbN + 1;
    if (prevStb && frameStb) b2b <= b2b + 1;
    prevStb <= frameStb;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [8:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitStb();
    do @(negedge clk); while (!frameStb);
  endtask

  // one 32-bit word over the serial link; sdIn must already hold inWord[31]
  task automatic runBits(input logic [31:0] inWord, input logic nextFirst,
                         output logic [31:0] outWord, output logic [31:0] firstLeft);
    for (int i = 0; i < 32; i++) begin
      waitStb();
      @(negedge clk);
      sdIn = (i < 31) ? inWord[30-i] : nextFirst;
      if (i == 0) regRd(9'h0C, firstLeft);
      @(negedge clk);
      outWord[31-i] = sdOut;
    end
  endtask

  task automatic tReset();
    logic [31:0] v;
    regRd(9'h00, v); chk(v == 32'h0, "R1 control", v, 32'h0);
    regRd(9'h04, v); chk(v == 32'h00350000, "R1 source", v, 32'h00350000);
    regRd(9'h0C, v); chk(v == 32'h0, "R1 counter", v, 32'h0);
    chk({sdOut, memWrEn, memRdEn} == 3'b000, "R1 outputs", {29'h0, sdOut, memWrEn, memRdEn}, 32'h0);
  endtask

  task automatic tMirror();
    logic [31:0] v;
    regWr(9'h38, 32'h1);
    regRd(9'h18, v); chk(v == 32'h1, "R2 length via base slot", v, 32'h1);
    regRd(9'h58, v); chk(v == 32'h1, "R2 length via mirror", v, 32'h1);
    regWr(9'h30, 32'h40);
    regRd(9'h10, v); chk(v == 32'h40, "R2 capture base mirror", v, 32'h40);
    regWr(9'h14, 32'h80);
    regRd(9'h08, v); chk(v == 32'h0, "R2 empty slot", v, 32'h0);
  endtask

  task automatic tSource();
    logic [31:0] v;
    regWr(9'h04, 32'h0047A000);
    regRd(9'h04, v); chk(v == 32'h0045A000, "R11 select 4 accepted", v, 32'h0045A000);
    regWr(9'h04, 32'h00972000);
    regRd(9'h04, v); chk(v == 32'h00452000, "R11 select 9 refused", v, 32'h00452000);
  endtask

  task automatic measure(input logic [31:0] ctl, input int expGap, input string req);
    int n;
    regWr(9'h00, ctl);
    waitStb();
    n = 0;
    do begin @(negedge clk); n++; end while (!frameStb);
    chk(n == expGap, req, n, expGap);
    regWr(9'h00, 32'h0);
  endtask

  task automatic tRate();
    measure(32'h0880, 6,  "R3 code 10");
    measure(32'h0280, 12, "R3 code 01");
    measure(32'h0080, 13, "R3 code 00");
    measure(32'h0A80, 6,  "R3 code 11");
  endtask

  task automatic tCapture();
    logic [31:0] o, l, v;
    int w0;
    w0 = wrN;
    sdIn = 1'b1;   // first bit of C3A50F81
    regWr(9'h00, 32'h0880);
    runBits(32'hC3A50F81, 1'b0, o, l);
    chk(l == 32'd63, "R4 load on first strobe", l, 32'd63);
    runBits(32'h1234ABCD, 1'b0, o, l);
    chk(l == 32'd31, "R4 counting down", l, 32'd31);
    regRd(9'h0C, v); chk(v == 32'd0, "R4 zero at pass end", v, 32'd0);
    runBits(32'h5A5AF00F, 1'b0, o, l);
    chk(l == 32'd63, "R4 reload after wrap", l, 32'd63);
    repeat (3) @(negedge clk);
    chk(wrN - w0 == 3, "R5 write count", wrN - w0, 3);
    chk(logA[w0[3:0]] == 32'h40 && logD[w0[3:0]] == 32'hC3A50F81, "R5 word 0", logD[w0[3:0]], 32'hC3A50F81);
    chk(logA[4'(w0+1)] == 32'h44 && logD[4'(w0+1)] == 32'h1234ABCD, "R5 word 1", logD[4'(w0+1)], 32'h1234ABCD);
    chk(logA[4'(w0+2)] == 32'h40, "R6 capture wraps to base", logA[4'(w0+2)], 32'h40);
    regWr(9'h00, 32'h0);
  endtask

  task automatic tPlay();
    logic [31:0] o, l;
    int r0, w0;
    r0 = rdN; w0 = wrN;
    regWr(9'h00, 32'h0904);
    runBits(32'h0, 1'b0, o, l); chk(o == 32'hA5F03C96, "R7 word 0", o, 32'hA5F03C96);
    runBits(32'h0, 1'b0, o, l); chk(o == 32'h0F0F8001, "R7 word 1", o, 32'h0F0F8001);
    runBits(32'h0, 1'b0, o, l); chk(o == 32'hA5F03C96, "R6 playback wraps", o, 32'hA5F03C96);
    chk(rdN - r0 == 3, "R7 read count", rdN - r0, 3);
    chk(wrN == w0, "R5 no write without capture", wrN - w0, 0);
    regWr(9'h00, 32'h0);
  endtask

  task automatic tMute();
    logic [31:0] o, l;
    regWr(9'h00, 32'h0900);
    runBits(32'h0, 1'b0, o, l);
    chk(o == 32'h0, "R8 output disabled", o, 32'h0);
    regWr(9'h00, 32'h0);
  endtask

  task automatic tPass();
    logic [31:0] o, l;
    int r0, w0;
    r0 = rdN; w0 = wrN;
    sdIn = 1'b1;   // first bit of 9B3CE107
    regWr(9'h00, 32'h08C4);
    runBits(32'h9B3CE107, 1'b0, o, l);
    chk(o == 32'h9B3CE107, "R9 serial loop", o, 32'h9B3CE107);
    repeat (3) @(negedge clk);
    chk(wrN - w0 == 2, "R9 two writes", wrN - w0, 2);
    chk(logA[w0[3:0]] == 32'h40, "R9 capture write first", logA[w0[3:0]], 32'h40);
    chk(logA[4'(w0+1)] == 32'h80 && mem[32] == 32'h9B3CE107, "R9 playback copy", mem[32], 32'h9B3CE107);
    chk(rdN == r0, "R9 no reads", rdN - r0, 0);
    regWr(9'h00, 32'h0);
  endtask

  task automatic tStop();
    logic [31:0] v;
    int w0, r0, s0;
    sdIn = 1'b1;
    regWr(9'h00, 32'h08C4);
    repeat (3) waitStb();
    repeat (2) @(negedge clk);
    chk(sdOut == 1'b1, "R10 output active before stop", sdOut, 1);
    regWr(9'h00, 32'h0);
    w0 = wrN; r0 = rdN; s0 = stbN;
    @(negedge clk);
    chk(sdOut == 1'b0, "R10 output low after stop", sdOut, 0);
    repeat (60) @(negedge clk);
    chk(wrN == w0 && rdN == r0 && stbN == s0, "R10 no activity", wrN + rdN + stbN, w0 + r0 + s0);
    regRd(9'h0C, v); chk(v == 32'h0, "R10 counter cleared", v, 32'h0);
    sdIn = 1'b0;
  endtask

  task automatic tLenZero();
    logic [31:0] v;
    int s0;
    regWr(9'h18, 32'h0);
    s0 = stbN;
    regWr(9'h00, 32'h0880);
    repeat (60) @(negedge clk);
    chk(stbN == s0, "R12 no strobes", stbN - s0, 0);
    regRd(9'h0C, v); chk(v == 32'h0, "R12 counter idle", v, 32'h0);
    regWr(9'h00, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[32] = 32'hA5F03C96;
    mem[33] = 32'h0F0F8001;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tMirror();
    tSource();
    tRate();
    tCapture();
    tPlay();
    tMute();
    tPass();
    tStop();
    tLenZero();
    chk(clash == 0, "R13 read/write clash", clash, 0);
    chk(b2b == 0, "R13 back-to-back strobes", b2b, 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule